// File: doc/BRIEF.md
# Display Controller Command Byte Parser

This block sits behind a serial byte receiver in a small display controller. It takes one byte per valid cycle. A select input says whether the byte is a command byte or a pixel byte. Pixel bytes go straight to a separate pixel port, registered once.

Command bytes are framed as an opcode followed by a number of argument bytes. The opcode alone decides how many arguments follow, from none up to eight. Arguments are collected into a small buffer. Once the last one arrives, the command takes effect.

- The column-window command loads a column start/end pair.
- The row-window command loads a row start/end pair.
- The addressing-mode command loads a remap byte.

Each of these three results comes with a one-cycle load strobe. Opcodes for analog settings (contrast, drive current, timing, grey levels) only have their arguments consumed. An unknown opcode produces a one-cycle error pulse.

The parser has two states:

- `ST_OPCODE` waits for an opcode.
- `ST_ARGS` collects arguments.

Its transitions are:

- **Open**: `ST_OPCODE` to `ST_ARGS`, on a known opcode that takes at least one argument.
- **Close**: `ST_ARGS` to `ST_OPCODE`, on the final argument byte.
- **Hold**: stays in the current state on every other byte, including zero-argument opcodes, the discard byte, unknown opcodes, pixel bytes and idle cycles.

Top module: `cmd_framer`

## Requirements
- R1: After reset the column window is 0..COL_SPAN-1 (0..63), the row window is 0..ROW_SPAN-1 (0..79), the remap byte is 0, and all strobes, the error pulse and pix_valid are low.
- R2: A valid byte with sel_data high appears on pix_byte with pix_valid high in the following cycle. It does not disturb command parsing.
- R3: Opcode 0x15 takes two arguments. On the cycle after the second one, col_lo = first mod 64, col_hi = second mod 64, and col_load pulses for one cycle.
- R4: Opcode 0x75 takes two arguments. On the cycle after the second one, row_lo = first mod 80, row_hi = second mod 80, and row_load pulses for one cycle.
- R5: Opcode 0xA0 takes one argument, which is stored whole as remap, with a remap_load pulse the cycle after. Bit 2 of remap selects vertical address increment.
- R6: Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF consume exactly one argument byte, with no visible effect.
- R7: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 consume no argument bytes. The next command byte is an opcode.
- R8: Opcode 0xB8 consumes exactly eight argument bytes, with no visible effect.
- R9: Byte 0xFF received as an opcode is dropped without error. The same value received as an argument byte counts as an argument.
- R10: Any other opcode raises bad_op for one cycle, the cycle after it is received. The parser then expects a new opcode.
- R11: Pixel bytes received in the middle of a command leave the collected arguments and their count intact. The command resumes when command bytes return.
- R12: Cycles with byte_valid low change no output and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | byte_in carries a byte this cycle |
| sel_data | input | 1 | 1 = pixel byte, 0 = command byte |
| byte_in | input | 8 | Incoming byte |
| pix_valid | output | 1 | pix_byte holds a pixel byte this cycle |
| pix_byte | output | 8 | Forwarded pixel byte |
| col_lo | output | $clog2(COL_SPAN) | Column window start |
| col_hi | output | $clog2(COL_SPAN) | Column window end |
| col_load | output | 1 | Column window updated this cycle |
| row_lo | output | $clog2(ROW_SPAN) | Row window start |
| row_hi | output | $clog2(ROW_SPAN) | Row window end |
| row_load | output | 1 | Row window updated this cycle |
| remap | output | 8 | Addressing-mode byte |
| remap_load | output | 1 | Remap byte updated this cycle |
| bad_op | output | 1 | Unknown opcode seen (one-cycle pulse) |

## Verification
The framer is driven with streams that mix opcodes of every argument count (zero, one, two and eight). Each ignored-argument command is followed directly by a remap command. That tells apart correct consumption from one byte too many or too few: a miscount would turn the remap opcode into an argument, or an argument into an opcode.

Argument values above the window spans separate a correct modulo from plain truncation. This matters most for the row span of 80, which is not a power of two.

The discard byte is sent both as an opcode and inside the grey-table arguments, and pixel bytes are interleaved halfway through a row command. Together these separate the opcode path from the argument path.

Back-to-back unknown opcodes and long idle gaps check the error pulse and the absence of stray strobes.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_OPCODE,
        ST_ARGS
    } cfr_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_COL,
        ACT_ROW,
        ACT_REMAP
    } cfr_act_e;
endpackage

// File: rtl/cfr_decode.sv
module cfr_decode
    import cfr_pkg::*;
#(
    parameter int MAX_ARGS = 8,
    localparam int CNT_W = $clog2(MAX_ARGS + 1)
) (
    input  logic [BYTE_W-1:0] opcode,
    output logic              known,
    output logic              skip,
    output logic [CNT_W-1:0]  nargs,
    output cfr_act_e          act
);
    always_comb begin
        known = 1'b1;
        skip  = 1'b0;
        nargs = '0;
        act   = ACT_NONE;
        case (opcode)
            8'h15: begin
                nargs = CNT_W'(2);
                act   = ACT_COL;
            end
            8'h75: begin
                nargs = CNT_W'(2);
                act   = ACT_ROW;
            end
            8'hA0: begin
                nargs = CNT_W'(1);
                act   = ACT_REMAP;
            end
            8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: begin
                nargs = CNT_W'(1);
            end
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3: begin
                nargs = '0;
            end
            8'hB8: begin
                nargs = CNT_W'(MAX_ARGS);
            end
            8'hFF: begin
                skip = 1'b1;
            end
            default: begin
                known = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cfr_argbuf.sv
module cfr_argbuf
    import cfr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]       wr_data,
    output logic [DEPTH*BYTE_W-1:0] slots
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                slot_q <= wr_data;
            end
        end
        assign slots[i*BYTE_W +: BYTE_W] = slot_q;
    end
endmodule

// File: rtl/cfr_window.sv
module cfr_window
    import cfr_pkg::*;
#(
    parameter int SPAN = 64,
    localparam int OUT_W = $clog2(SPAN)
) (
    input  logic [BYTE_W-1:0] first_arg,
    input  logic [BYTE_W-1:0] second_arg,
    output logic [OUT_W-1:0]  lo,
    output logic [OUT_W-1:0]  hi
);
    always_comb begin
        lo = OUT_W'(32'(first_arg) % SPAN);
        hi = OUT_W'(32'(second_arg) % SPAN);
    end
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
    import cfr_pkg::*;
#(
    parameter int MAX_ARGS = 8,
    parameter int COL_SPAN = 64,
    parameter int ROW_SPAN = 80,
    localparam int CNT_W = $clog2(MAX_ARGS + 1),
    localparam int IDX_W = (MAX_ARGS > 1) ? $clog2(MAX_ARGS) : 1,
    localparam int COL_W = $clog2(COL_SPAN),
    localparam int ROW_W = $clog2(ROW_SPAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic              sel_data,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              pix_valid,
    output logic [BYTE_W-1:0] pix_byte,
    output logic [COL_W-1:0]  col_lo,
    output logic [COL_W-1:0]  col_hi,
    output logic              col_load,
    output logic [ROW_W-1:0]  row_lo,
    output logic [ROW_W-1:0]  row_hi,
    output logic              row_load,
    output logic [BYTE_W-1:0] remap,
    output logic              remap_load,
    output logic              bad_op
);
    cfr_state_e          state_q, state_d;
    logic [BYTE_W-1:0]   op_q;
    logic [CNT_W-1:0]    cnt_q;

    logic                is_cmd;
    logic [BYTE_W-1:0]   dec_in;
    logic                dec_known, dec_skip;
    logic [CNT_W-1:0]    dec_nargs;
    cfr_act_e            dec_act;
    logic                open_cmd, last_arg, unknown_op;
    logic [MAX_ARGS*BYTE_W-1:0] slots;
    logic [BYTE_W-1:0]   arg0, arg1;
    logic [COL_W-1:0]    col_lo_n, col_hi_n;
    logic [ROW_W-1:0]    row_lo_n, row_hi_n;

    assign is_cmd = byte_valid && !sel_data;
    assign dec_in = (state_q == ST_OPCODE) ? byte_in : op_q;

    cfr_decode #(.MAX_ARGS(MAX_ARGS)) u_decode (
        .opcode (dec_in),
        .known  (dec_known),
        .skip   (dec_skip),
        .nargs  (dec_nargs),
        .act    (dec_act)
    );

    cfr_argbuf #(.DEPTH(MAX_ARGS)) u_argbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (is_cmd && (state_q == ST_ARGS)),
        .wr_idx  (IDX_W'(cnt_q)),
        .wr_data (byte_in),
        .slots   (slots)
    );

    // the final argument bypasses the buffer so results load without delay
    assign arg0 = (cnt_q == CNT_W'(0)) ? byte_in : slots[0 +: BYTE_W];
    assign arg1 = (cnt_q == CNT_W'(1)) ? byte_in : slots[BYTE_W +: BYTE_W];

    cfr_window #(.SPAN(COL_SPAN)) u_colwin (
        .first_arg  (arg0),
        .second_arg (arg1),
        .lo         (col_lo_n),
        .hi         (col_hi_n)
    );

    cfr_window #(.SPAN(ROW_SPAN)) u_rowwin (
        .first_arg  (arg0),
        .second_arg (arg1),
        .lo         (row_lo_n),
        .hi         (row_hi_n)
    );

    assign open_cmd   = is_cmd && (state_q == ST_OPCODE) && dec_known
                        && !dec_skip && (dec_nargs != '0);
    assign unknown_op = is_cmd && (state_q == ST_OPCODE) && !dec_known;
    assign last_arg   = is_cmd && (state_q == ST_ARGS)
                        && ((cnt_q + CNT_W'(1)) == dec_nargs);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPCODE: if (open_cmd) state_d = ST_ARGS;
            ST_ARGS:   if (last_arg) state_d = ST_OPCODE;
        endcase
    end

    // state register with opcode and argument count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OPCODE;
            op_q    <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (open_cmd) begin
                op_q  <= byte_in;
                cnt_q <= '0;
            end else if (last_arg) begin
                cnt_q <= '0;
            end else if (is_cmd && (state_q == ST_ARGS)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid  <= 1'b0;
            pix_byte   <= '0;
            col_lo     <= '0;
            col_hi     <= COL_W'(COL_SPAN - 1);
            col_load   <= 1'b0;
            row_lo     <= '0;
            row_hi     <= ROW_W'(ROW_SPAN - 1);
            row_load   <= 1'b0;
            remap      <= '0;
            remap_load <= 1'b0;
            bad_op     <= 1'b0;
        end else begin
            pix_valid  <= byte_valid && sel_data;
            col_load   <= 1'b0;
            row_load   <= 1'b0;
            remap_load <= 1'b0;
            bad_op     <= unknown_op;
            if (byte_valid && sel_data) begin
                pix_byte <= byte_in;
            end
            if (last_arg) begin
                unique case (dec_act)
                    ACT_COL: begin
                        col_lo   <= col_lo_n;
                        col_hi   <= col_hi_n;
                        col_load <= 1'b1;
                    end
                    ACT_ROW: begin
                        row_lo   <= row_lo_n;
                        row_hi   <= row_hi_n;
                        row_load <= 1'b1;
                    end
                    ACT_REMAP: begin
                        remap      <= arg0;
                        remap_load <= 1'b1;
                    end
                    ACT_NONE: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
    parameter int COL_SPAN = 64,
    parameter int ROW_SPAN = 80,
    localparam int COL_W = $clog2(COL_SPAN),
    localparam int ROW_W = $clog2(ROW_SPAN)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             byte_valid,
    input logic             sel_data,
    input logic [7:0]       byte_in,
    input logic             pix_valid,
    input logic [7:0]       pix_byte,
    input logic [COL_W-1:0] col_lo,
    input logic [COL_W-1:0] col_hi,
    input logic             col_load,
    input logic [ROW_W-1:0] row_lo,
    input logic [ROW_W-1:0] row_hi,
    input logic             row_load,
    input logic             remap_load,
    input logic             bad_op
);
    logic seen;
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_col_in_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(col_lo) < COL_SPAN) && (32'(col_hi) < COL_SPAN));

    assert_row_in_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(row_lo) < ROW_SPAN) && (32'(row_hi) < ROW_SPAN));

    assert_one_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({col_load, row_load, remap_load, bad_op}));

    assert_err_from_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && bad_op) |-> $past(byte_valid && !sel_data));

    assert_pix_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && pix_valid) |-> ($past(byte_valid && sel_data) && pix_byte == $past(byte_in)));

    assert_col_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !col_load) |-> ($stable(col_lo) && $stable(col_hi)));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(byte_valid)) |-> !(col_load || row_load || remap_load || bad_op || pix_valid));
endmodule

bind cmd_framer cfr_checker #(.COL_SPAN(COL_SPAN), .ROW_SPAN(ROW_SPAN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .sel_data   (sel_data),
    .byte_in    (byte_in),
    .pix_valid  (pix_valid),
    .pix_byte   (pix_byte),
    .col_lo     (col_lo),
    .col_hi     (col_hi),
    .col_load   (col_load),
    .row_lo     (row_lo),
    .row_hi     (row_hi),
    .row_load   (row_load),
    .remap_load (remap_load),
    .bad_op     (bad_op)
);

// File: tb/tb_cmd_framer.sv
module tb_cmd_framer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_valid = 1'b0;
    logic       sel_data = 1'b0;
    logic [7:0] byte_in = '0;
    logic       pix_valid, col_load, row_load, remap_load, bad_op;
    logic [7:0] pix_byte, remap;
    logic [5:0] col_lo, col_hi;
    logic [6:0] row_lo, row_hi;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_framer dut (
        .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .sel_data(sel_data),
        .byte_in(byte_in), .pix_valid(pix_valid), .pix_byte(pix_byte),
        .col_lo(col_lo), .col_hi(col_hi), .col_load(col_load),
        .row_lo(row_lo), .row_hi(row_hi), .row_load(row_load),
        .remap(remap), .remap_load(remap_load), .bad_op(bad_op)
    );

    // ---------------- behavioural reference model ----------------
    int e_col_lo, e_col_hi, e_row_lo, e_row_hi, e_remap, e_pix;
    bit e_col_ld, e_row_ld, e_rm_ld, e_bad, e_pv;
    int pending = -1;
    int argq[$];

    function automatic int arg_count(int op);
        if (op == 'h15 || op == 'h75) return 2;
        if (op == 'hB8) return 8;
        if (op == 'hA0 || op == 'h81 || op == 'hA1 || op == 'hA2 || op == 'hA8 ||
            op == 'hAD || op == 'hB1 || op == 'hB2 || op == 'hB3 || op == 'hBC ||
            op == 'hBE || op == 'hBF) return 1;
        if ((op >= 'h84 && op <= 'h86) || (op >= 'hA4 && op <= 'hA7) ||
            op == 'hAE || op == 'hAF || op == 'hE3) return 0;
        return -1;
    endfunction

    always @(posedge clk) begin
        e_col_ld = 0; e_row_ld = 0; e_rm_ld = 0; e_bad = 0; e_pv = 0;
        if (!rst_n) begin
            e_col_lo = 0; e_col_hi = 63; e_row_lo = 0; e_row_hi = 79;
            e_remap = 0; e_pix = 0; pending = -1; argq.delete();
        end else if (byte_valid) begin
            if (sel_data) begin
                e_pv = 1; e_pix = int'(byte_in);
            end else if (pending < 0) begin
                if (byte_in != 8'hFF) begin
                    if (arg_count(int'(byte_in)) < 0) e_bad = 1;
                    else if (arg_count(int'(byte_in)) > 0) begin
                        pending = int'(byte_in); argq.delete();
                    end
                end
            end else begin
                argq.push_back(int'(byte_in));
                if (argq.size() == arg_count(pending)) begin
                    if (pending == 'h15) begin
                        e_col_lo = argq[0] % 64; e_col_hi = argq[1] % 64; e_col_ld = 1;
                    end else if (pending == 'h75) begin
                        e_row_lo = argq[0] % 80; e_row_hi = argq[1] % 80; e_row_ld = 1;
                    end else if (pending == 'hA0) begin
                        e_remap = argq[0]; e_rm_ld = 1;
                    end
                    pending = -1;
                end
            end
        end
    end

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R2", "pix_valid", int'(pix_valid), int'(e_pv));
            if (e_pv) cmp("R2", "pix_byte", int'(pix_byte), e_pix);
            cmp("R3", "col_lo", int'(col_lo), e_col_lo);
            cmp("R3", "col_hi", int'(col_hi), e_col_hi);
            cmp("R3", "col_load", int'(col_load), int'(e_col_ld));
            cmp("R4", "row_lo", int'(row_lo), e_row_lo);
            cmp("R4", "row_hi", int'(row_hi), e_row_hi);
            cmp("R4", "row_load", int'(row_load), int'(e_row_ld));
            cmp("R5", "remap", int'(remap), e_remap);
            cmp("R5", "remap_load", int'(remap_load), int'(e_rm_ld));
            cmp("R10", "bad_op", int'(bad_op), int'(e_bad));
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(bit dsel, logic [7:0] b);
        byte_valid = 1'b1; sel_data = dsel; byte_in = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic idle(int n);
        byte_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset state
                cmp("R1", "reset col_hi", int'(col_hi), 63);
                cmp("R1", "reset row_hi", int'(row_hi), 79);
                cmp("R1", "reset remap", int'(remap), 0);
                cmp("R1", "reset strobes", int'({col_load, row_load, remap_load, bad_op, pix_valid}), 0);

                put(1, 8'h3C);
                cmp("R2", "pixel forwarded", int'(pix_byte), 'h3C);

                put(0, 8'h15); put(0, 8'h47); put(0, 8'h85);
                cmp("R3", "col window", int'({col_load, col_lo, col_hi}), (1 << 12) | (7 << 6) | 5);

                put(0, 8'h75); put(0, 8'hF5); put(0, 8'h50);
                cmp("R4", "row mod 80", int'({row_load, row_lo, row_hi}), (1 << 14) | (5 << 7) | 0);
                put(0, 8'h75); put(0, 8'h4F); put(0, 8'hA0);
                cmp("R4", "row bounds", int'({row_lo, row_hi}), (79 << 7) | 0);

                put(0, 8'hA0); put(0, 8'h04);
                cmp("R5", "remap vertical bit", int'(remap[2]), 1);

                put(0, 8'h81); put(0, 8'h15);
                cmp("R6", "arg not opcode", int'(col_load), 0);
                put(0, 8'hA0); put(0, 8'h33);
                cmp("R6", "next opcode parsed", int'(remap), 'h33);
                put(0, 8'hBF); put(0, 8'hA0); put(0, 8'hA0); put(0, 8'h3A);
                cmp("R6", "one-arg op", int'(remap), 'h3A);

                put(0, 8'hA4); put(0, 8'hE3); put(0, 8'hA0); put(0, 8'h11);
                cmp("R7", "zero-arg ops", int'(remap), 'h11);

                put(0, 8'hB8);
                put(0, 8'h75); put(0, 8'h01); put(0, 8'hFF); put(0, 8'hA0);
                put(0, 8'h02); put(0, 8'h15); put(0, 8'h03);
                cmp("R8", "grey arg no effect", int'({row_load, remap_load}), 0);
                put(0, 8'h04);
                put(0, 8'hA0); put(0, 8'h22);
                cmp("R8", "eight args consumed", int'(remap), 'h22);

                put(0, 8'hFF);
                cmp("R9", "discard no error", int'(bad_op), 0);
                put(0, 8'hA0); put(0, 8'h44);
                cmp("R9", "after discard", int'(remap), 'h44);

                put(0, 8'h00);
                cmp("R10", "unknown pulse", int'(bad_op), 1);
                put(0, 8'h01);
                cmp("R10", "second unknown", int'(bad_op), 1);
                idle(1);
                cmp("R10", "pulse ends", int'(bad_op), 0);
                put(0, 8'hA0); put(0, 8'h55);
                cmp("R10", "recovered", int'(remap), 'h55);

                put(0, 8'h75); put(0, 8'h10);
                put(1, 8'hAB);
                cmp("R11", "pixel mid-command", int'(pix_byte), 'hAB);
                idle(2);
                put(0, 8'h20);
                cmp("R11", "row resumes", int'({row_lo, row_hi}), (16 << 7) | 32);

                idle(5);
                cmp("R12", "idle quiet", int'({col_load, row_load, remap_load, bad_op, pix_valid}), 0);
                cmp("R12", "idle holds", int'(remap), 'h55);
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule